// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block is the control side of a bus-master DMA channel in a SCSI host adapter. Software programs a start count, a start address and a start descriptor-list address, then writes a command word. A START command copies the three start values into their working copies, clears the status bits and enables the transfer toward the SCSI core. IDLE withdraws that enable. ABORT sends a one-cycle cancel pulse. BLAST is stored but has no other effect.

While a transfer runs, the SCSI core offers data chunks through a request and length handshake. The block limits each chunk to the remaining working count and returns the granted length. It then lowers the working count and raises the working address by the amount granted. DONE is set when the count reaches zero, or when the core reports that the command has finished. The core's interrupt flag is merged into the status word on reads. Software clears the sticky status bits in one of two ways, selected by a mode input: write-one-to-clear, or clear-on-read.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset the command, start count, start address, start list address, working count and status read 0. The working address reads 0xFFFFFFFF, the working list address reads 0xFFFFFFFD, and dma_run, dma_abort and irq are 0.
- R2: Register index 0 is the command, 1 the start count, 2 the start address, 3 the working count, 4 the working address, 5 the status and 6 and 7 the start and working list addresses. Writes to indices 0, 1, 2 and 6 are read back unchanged. Writes to 3, 4 and 7 are ignored.
- R3: Command bits [1:0] encode the operation: 3 is START, 0 is IDLE, 2 is ABORT and 1 is BLAST. START loads index 3 from 1, index 4 from 2 and index 7 from 6, clears status bits [5:0] and raises dma_run. IDLE drops dma_run. ABORT pulses dma_abort for exactly one cycle. BLAST changes nothing but the stored command.
- R4: A chunk is accepted when xfer_to_mem equals command bit 7. xfer_grant is then the smaller of xfer_len and the working count. The working count drops and the working address rises by xfer_grant. The new values are visible after that clock edge.
- R5: A chunk whose direction differs from command bit 7 gets xfer_grant 0 and leaves the working count and address unchanged.
- R6: Status bit 3 (DONE) is set when an accepted chunk brings the working count to 0. It is also set by core_cmd_done, which forces the working count to 0.
- R7: With stat_w1c_mode = 1, a status write clears those of bits 1, 2 and 3 that are written as 1. All other status bits are unaffected.
- R8: With stat_w1c_mode = 0, status writes are ignored. A status read returns the current value and then clears bits 1, 2 and 3.
- R9: A status read shows bit 4 set whenever core_irq is 1.
- R10: irq is 1 exactly while status bit 3 and command bit 6 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_w1c_mode | input | 1 | 1: write-one-to-clear status; 0: clear-on-read |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_idx (combinational) |
| xfer_req | input | 1 | Core offers a data chunk this cycle |
| xfer_to_mem | input | 1 | Chunk direction, 1 = device to memory |
| xfer_len | input | LEN_W | Requested chunk length |
| xfer_grant | output | LEN_W | Granted length, 0 if the chunk is dropped |
| xfer_addr | output | DATA_W | Current working address |
| core_irq | input | 1 | Core interrupt flag |
| core_cmd_done | input | 1 | Core command-completion pulse |
| dma_run | output | 1 | Transfer enable toward the core |
| dma_abort | output | 1 | One-cycle cancel pulse |
| irq | output | 1 | Done interrupt |

## Verification
reg_rdata, xfer_grant and the merged interrupt bit are combinational. The bench samples them one time unit after driving the request, still inside the same cycle. Every register effect (working count, address, status, dma_run, dma_abort, irq) lands on the first rising edge after the stimulus. The bench therefore checks those effects at the falling edge that follows that rising edge. A clear-on-read happens on the edge that ends the read cycle, so the cleared value is checked on a second read, not on the first.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_BLAST = 2'd1,
      OP_ABORT = 2'd2,
      OP_START = 2'd3
   } dma_op_e;

   localparam int IDX_CMD   = 0;
   localparam int IDX_SCNT  = 1;
   localparam int IDX_SADDR = 2;
   localparam int IDX_WCNT  = 3;
   localparam int IDX_WADDR = 4;
   localparam int IDX_STAT  = 5;
   localparam int IDX_SLIST = 6;
   localparam int IDX_WLIST = 7;

   localparam int CB_IRQ_DONE = 6;
   localparam int CB_TO_MEM   = 7;

   localparam int STAT_W   = 6;
   localparam int SB_DONE  = 3;
   localparam int SB_SCSI  = 4;
   localparam logic [STAT_W-1:0] STICKY_MASK = 6'b001110;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
   import scsi_dma_pkg::*;
(
   input  logic       cmd_wr,
   input  logic [1:0] op_bits,
   output logic       op_start,
   output logic       op_idle,
   output logic       op_abort
);
   dma_op_e op;

   always_comb begin
      op       = dma_op_e'(op_bits);
      op_start = cmd_wr && (op == OP_START);
      op_idle  = cmd_wr && (op == OP_IDLE);
      op_abort = cmd_wr && (op == OP_ABORT);
   end
endmodule

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              req,
   input  logic              to_mem,
   input  logic              cmd_to_mem,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] wcount,
   output logic              accept,
   output logic [LEN_W-1:0]  grant,
   output logic              last
);
   localparam int PAD_W = DATA_W - LEN_W;

   logic [DATA_W-1:0] len_ext;
   logic [DATA_W-1:0] lim;

   always_comb begin
      len_ext = {{PAD_W{1'b0}}, len};
      accept  = req && (to_mem == cmd_to_mem);
      lim     = (len_ext < wcount) ? len_ext : wcount;
      grant   = accept ? lim[LEN_W-1:0] : '0;
      last    = accept && (lim == wcount);
   end
endmodule

// File: rtl/dma_stat_unit.sv
module dma_stat_unit #(
   parameter int NBITS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wipe,
   input  logic [NBITS-1:0] set_mask,
   input  logic [NBITS-1:0] clr_mask,
   output logic [NBITS-1:0] stat
);
   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            stat[b] <= 1'b0;
         else if (wipe)         stat[b] <= 1'b0;
         else if (set_mask[b])  stat[b] <= 1'b1;
         else if (clr_mask[b])  stat[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
   import scsi_dma_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                LEN_W     = 16,
   parameter logic [DATA_W-1:0] WADDR_RST = 32'hFFFF_FFFF,
   parameter logic [DATA_W-1:0] WLIST_RST = 32'hFFFF_FFFD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_w1c_mode,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              xfer_req,
   input  logic              xfer_to_mem,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic [LEN_W-1:0]  xfer_grant,
   output logic [DATA_W-1:0] xfer_addr,
   input  logic              core_irq,
   input  logic              core_cmd_done,
   output logic              dma_run,
   output logic              dma_abort,
   output logic              irq
);
   localparam int NREG  = 8;
   localparam int PAD_W = DATA_W - LEN_W;
   localparam int SPAD  = DATA_W - STAT_W;

   if (DATA_W < 8) begin : g_chk_data
      $error("DATA_W must hold the command bits");
   end
   if (LEN_W >= DATA_W) begin : g_chk_len
      $error("LEN_W must be narrower than DATA_W");
   end

   logic [NREG-1:0]   wr_hit;
   logic              op_start, op_idle, op_abort;
   logic [DATA_W-1:0] cmd_q, scnt_q, saddr_q, slist_q;
   logic [DATA_W-1:0] wcnt_q, waddr_q, wlist_q;
   logic [STAT_W-1:0] stat_q, set_mask, clr_mask;
   logic              accept, last;
   logic              run_q, abort_q;

   for (genvar i = 0; i < NREG; i++) begin : g_hit
      assign wr_hit[i] = reg_wr && (reg_idx == 3'(i));
   end

   dma_cmd_decode u_dec (
      .cmd_wr   (wr_hit[IDX_CMD]),
      .op_bits  (reg_wdata[1:0]),
      .op_start (op_start),
      .op_idle  (op_idle),
      .op_abort (op_abort)
   );

   dma_chunk_calc #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chunk (
      .req        (xfer_req),
      .to_mem     (xfer_to_mem),
      .cmd_to_mem (cmd_q[CB_TO_MEM]),
      .len        (xfer_len),
      .wcount     (wcnt_q),
      .accept     (accept),
      .grant      (xfer_grant),
      .last       (last)
   );

   always_comb begin
      set_mask          = '0;
      set_mask[SB_DONE] = core_cmd_done || last;
      clr_mask          = '0;
      if (stat_w1c_mode && wr_hit[IDX_STAT])
         clr_mask = reg_wdata[STAT_W-1:0] & STICKY_MASK;
      else if (!stat_w1c_mode && reg_rd && (reg_idx == 3'(IDX_STAT)))
         clr_mask = STICKY_MASK;
   end

   dma_stat_unit #(.NBITS(STAT_W)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .wipe     (op_start),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .stat     (stat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         scnt_q  <= '0;
         saddr_q <= '0;
         slist_q <= '0;
      end else begin
         if (wr_hit[IDX_CMD])   cmd_q   <= reg_wdata;
         if (wr_hit[IDX_SCNT])  scnt_q  <= reg_wdata;
         if (wr_hit[IDX_SADDR]) saddr_q <= reg_wdata;
         if (wr_hit[IDX_SLIST]) slist_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt_q  <= '0;
         waddr_q <= WADDR_RST;
         wlist_q <= WLIST_RST;
      end else if (op_start) begin
         wcnt_q  <= scnt_q;
         waddr_q <= saddr_q;
         wlist_q <= slist_q;
      end else begin
         if (core_cmd_done)  wcnt_q <= '0;
         else if (accept)    wcnt_q <= wcnt_q - {{PAD_W{1'b0}}, xfer_grant};
         if (accept)         waddr_q <= waddr_q + {{PAD_W{1'b0}}, xfer_grant};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         if (op_start)     run_q <= 1'b1;
         else if (op_idle) run_q <= 1'b0;
         abort_q <= op_abort;
      end
   end

   always_comb begin
      unique case (reg_idx)
         3'(IDX_CMD):   reg_rdata = cmd_q;
         3'(IDX_SCNT):  reg_rdata = scnt_q;
         3'(IDX_SADDR): reg_rdata = saddr_q;
         3'(IDX_WCNT):  reg_rdata = wcnt_q;
         3'(IDX_WADDR): reg_rdata = waddr_q;
         3'(IDX_STAT):  reg_rdata = {{SPAD{1'b0}}, stat_q | (STAT_W'(core_irq) << SB_SCSI)};
         3'(IDX_SLIST): reg_rdata = slist_q;
         default:       reg_rdata = wlist_q;
      endcase
   end

   assign xfer_addr = waddr_q;
   assign dma_run   = run_q;
   assign dma_abort = abort_q;
   assign irq       = stat_q[SB_DONE] && cmd_q[CB_IRQ_DONE];

endmodule

// File: rtl/scsi_dma_chan_chk.sv
module scsi_dma_chan_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [2:0]        reg_idx,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              stat_w1c_mode,
   input logic              xfer_req,
   input logic              xfer_to_mem,
   input logic              core_cmd_done,
   input logic              cmd_to_mem,
   input logic [DATA_W-1:0] scnt,
   input logic [DATA_W-1:0] wcnt,
   input logic [DATA_W-1:0] waddr,
   input logic [5:0]        stat,
   input logic              dma_run
);
   logic start_wr;
   assign start_wr = reg_wr && (reg_idx == 3'd0) && (reg_wdata[1:0] == 2'b11);

   assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (wcnt == $past(scnt)) && (stat == 6'd0) && dma_run);

   assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !start_wr |=> wcnt <= $past(wcnt));

   assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && (xfer_to_mem != cmd_to_mem) && !reg_wr && !core_cmd_done)
      |=> $stable(wcnt) && $stable(waddr));

   assert_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (core_cmd_done && !start_wr) |=> (wcnt == '0) && stat[3]);

   assert_rdmode_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_idx == 3'd5) && !stat_w1c_mode && !reg_rd && !xfer_req && !core_cmd_done)
      |=> $stable(stat));
endmodule

bind scsi_dma_chan scsi_dma_chan_chk #(.DATA_W(DATA_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr        (reg_wr),
   .reg_rd        (reg_rd),
   .reg_idx       (reg_idx),
   .reg_wdata     (reg_wdata),
   .stat_w1c_mode (stat_w1c_mode),
   .xfer_req      (xfer_req),
   .xfer_to_mem   (xfer_to_mem),
   .core_cmd_done (core_cmd_done),
   .cmd_to_mem    (cmd_q[7]),
   .scnt          (scnt_q),
   .wcnt          (wcnt_q),
   .waddr         (waddr_q),
   .stat          (stat_q),
   .dma_run       (dma_run)
);

// File: tb/scsi_dma_chan_tb_top.sv
`timescale 1ns/100ps
module scsi_dma_chan_tb_top;
   localparam int DW = 32;
   localparam int LW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          w1c = 1'b1;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]    reg_idx = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          xfer_req = 1'b0, xfer_to_mem = 1'b0;
   logic [LW-1:0] xfer_len = '0;
   logic [LW-1:0] xfer_grant;
   logic [DW-1:0] xfer_addr;
   logic          core_irq = 1'b0, core_cmd_done = 1'b0;
   logic          dma_run, dma_abort, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   scsi_dma_chan #(.DATA_W(DW), .LEN_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .stat_w1c_mode(w1c),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .xfer_req(xfer_req), .xfer_to_mem(xfer_to_mem), .xfer_len(xfer_len),
      .xfer_grant(xfer_grant), .xfer_addr(xfer_addr),
      .core_irq(core_irq), .core_cmd_done(core_cmd_done),
      .dma_run(dma_run), .dma_abort(dma_abort), .irq(irq)
   );

   // op: 0 write, 1 read-compare, 2 chunk (data = {dir, len}, exp = grant)
   localparam int NV = 22;
   localparam logic [68:0] VEC [NV] = '{
      {2'd0, 3'd1, 32'h0000_0100, 32'h0},            // R2 start count
      {2'd0, 3'd2, 32'h8000_0000, 32'h0},            // R2 start address
      {2'd0, 3'd6, 32'h0000_1234, 32'h0},            // R2 start list
      {2'd0, 3'd0, 32'h0000_0043, 32'h0},            // R3 START
      {2'd1, 3'd3, 32'h0, 32'h0000_0100},            // R3
      {2'd1, 3'd4, 32'h0, 32'h8000_0000},            // R3
      {2'd1, 3'd7, 32'h0, 32'h0000_1234},            // R3
      {2'd2, 3'd0, 32'h0000_0040, 32'h0000_0040},    // R4
      {2'd1, 3'd3, 32'h0, 32'h0000_00C0},            // R4
      {2'd1, 3'd4, 32'h0, 32'h8000_0040},            // R4
      {2'd2, 3'd0, 32'h0001_0010, 32'h0},            // R5 wrong direction
      {2'd1, 3'd3, 32'h0, 32'h0000_00C0},            // R5
      {2'd2, 3'd0, 32'h0000_0200, 32'h0000_00C0},    // R4 clamp
      {2'd1, 3'd3, 32'h0, 32'h0},                    // R4
      {2'd1, 3'd4, 32'h0, 32'h8000_0100},            // R4
      {2'd1, 3'd5, 32'h0, 32'h0000_0008},            // R6 done
      {2'd0, 3'd3, 32'h0000_0055, 32'h0},            // R2 ignored write
      {2'd1, 3'd3, 32'h0, 32'h0},                    // R2
      {2'd0, 3'd5, 32'h0000_0008, 32'h0},            // R7 clear done
      {2'd1, 3'd5, 32'h0, 32'h0},                    // R7
      {2'd0, 3'd0, 32'h0000_0041, 32'h0},            // R3 BLAST
      {2'd1, 3'd0, 32'h0, 32'h0000_0041}             // R2 command readback
   };

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [2:0] idx, input logic [DW-1:0] exp);
      @(negedge clk);
      reg_rd = 1'b1; reg_idx = idx;
      #1 check(req, reg_rdata, exp);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chunk(input string req, input logic dir, input logic [LW-1:0] len,
                        input logic [LW-1:0] exp);
      @(negedge clk);
      xfer_req = 1'b1; xfer_to_mem = dir; xfer_len = len;
      #1 check(req, DW'(xfer_grant), DW'(exp));
      @(negedge clk);
      xfer_req = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd("R1", 3'd0, 32'h0);
      rd("R1", 3'd3, 32'h0);
      rd("R1", 3'd4, 32'hFFFF_FFFF);
      rd("R1", 3'd5, 32'h0);
      rd("R1", 3'd7, 32'hFFFF_FFFD);
      check("R1", {29'd0, dma_run, dma_abort, irq}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [68:0] v;
         v = VEC[i];
         case (v[68:67])
            2'd0: wr(v[66:64], v[63:32]);
            2'd1: rd($sformatf("table %0d", i), v[66:64], v[31:0]);
            default: chunk($sformatf("table %0d", i), v[48], v[47:32], v[15:0]);
         endcase
      end
      check("R3 BLAST keeps run", DW'(dma_run), 32'd1);

      // R3 ABORT one-cycle pulse, IDLE drops run
      wr(3'd0, 32'h42);
      check("R3 abort pulse", DW'(dma_abort), 32'd1);
      @(negedge clk);
      check("R3 abort one cycle", DW'(dma_abort), 32'd0);
      wr(3'd0, 32'h40);
      check("R3 idle", DW'(dma_run), 32'd0);

      // R10 irq from DONE with enable bit 6
      wr(3'd1, 32'h8);
      wr(3'd0, 32'h43);
      check("R3 start run", DW'(dma_run), 32'd1);
      check("R10 irq low", DW'(irq), 32'd0);
      chunk("R4", 1'b0, 16'd8, 16'd8);
      check("R10 irq high", DW'(irq), 32'd1);

      // R9 core interrupt merged
      core_irq = 1'b1;
      rd("R9", 3'd5, 32'h18);
      core_irq = 1'b0;

      // R6 completion forces count to zero; R3 START clears status
      wr(3'd1, 32'h20);
      wr(3'd0, 32'h03);
      rd("R3 status cleared", 3'd5, 32'h0);
      rd("R3", 3'd3, 32'h20);
      @(negedge clk); core_cmd_done = 1'b1;
      @(negedge clk); core_cmd_done = 1'b0;
      rd("R6 count", 3'd3, 32'h0);
      rd("R6 done", 3'd5, 32'h08);

      // R7 writing only the abort bit keeps DONE
      wr(3'd5, 32'h04);
      rd("R7", 3'd5, 32'h08);

      // R8 clear-on-read mode
      w1c = 1'b0;
      wr(3'd5, 32'h08);
      rd("R8 write ignored", 3'd5, 32'h08);
      rd("R8 cleared by read", 3'd5, 32'h0);

      finish_run();
   end
endmodule